// File: doc/BRIEF.md
# Row Switcher Pattern Sequencer

The sequencer drives the four control lines of a row switcher (gate, clear, data, clock) while a pixel sensor is read out one row at a time. Each row is built from a short run of pattern words taken from one of two pattern stores. One store serves normal running. The other serves a gated sequence that is placed into the row stream on request. A pattern word holds one bit per output for every fine time slot, so each edge on every line can be placed on its own. The block advances one slot per fast clock.

A gated sequence is requested with a command pulse that carries a target row and a length in rows. The request waits until the row counter next enters the target row, and the gated store then supplies that many rows. Both stores hold their words with a single-error-correcting, double-error-detecting Hamming code. Words are corrected on the way to the outputs. At the start of every frame a scrub pass also visits every word and writes back any word that holds a single flipped bit. Words are loaded through a valid/ready write port. That port has a mask input that flips chosen codeword bits, so faults can be placed on purpose.

Top module: `rowsw_seq`

## Requirements
- R1: With `en` high, every row plays the DEPTH words of the selected store in address order, SLOTS slots per word, one slot per clock. Slot s of output k comes from data bit k*SLOTS+s, where k is 0 for gate, 1 for clear, 2 for data and 3 for clock. The output pins show a slot on the clock after the counters point at it.
- R2: Rows outside a gated window use the run store (`wr_bank`=0). Rows inside one use the gated store (`wr_bank`=1). `gated` is high while gated-store slots are on the pins.
- R3: The row counter wraps from ROWS-1 to 0. `frame_start` is high for exactly the one cycle in which the pins show the first slot of row 0.
- R4: A `gate_cmd` pulse captures `gate_row` and `gate_len` as a pending request. The window opens when the counter next enters the captured row, but not while an earlier window is still running, and it then lasts `gate_len` rows. A length of 0 drops the request with no effect. A newer command replaces a pending one. Entry into row 0 straight from reset or idle does not count as entering a row.
- R5: A single flipped bit anywhere in a stored codeword (data, check or overall parity) does not change the slots played.
- R6: Each frame start begins a scrub pass of 2*DEPTH cycles. The pass visits run words 0..DEPTH-1 and then gated words 0..DEPTH-1, one per cycle. A word with a single error is rewritten clean, and `ecc_fix` pulses on the cycle after its visit.
- R7: `wr_ready` is low for the whole scrub pass and high otherwise. A word is stored when `wr_valid` and `wr_ready` are both high at a clock edge. Its codeword, laid out as {overall parity, check[P-1:0], data[W-1:0]}, is stored XOR `wr_inject`. The new content reaches the pins from the next clock onward.
- R8: A word with two flipped data bits is not rewritten by the scrub. Its visit sets the sticky `ecc_dbl` flag, which only reset clears, and playback shows the stored data bits uncorrected.
- R9: After reset all outputs are low, `wr_ready` is high and the stores hold zero words. While `en` is low the counters sit at row 0, slot 0, any running gated window is dropped and all pattern pins, `gated` and `frame_start` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the sequencer idle |
| gate_cmd | input | 1 | Single-cycle gated request |
| gate_row | input | clog2(ROWS) | Row at which the gated window opens |
| gate_len | input | LEN_W | Window length in rows |
| wr_valid | input | 1 | Pattern write offered |
| wr_ready | output | 1 | Write port can accept this cycle |
| wr_bank | input | 1 | 0 run store, 1 gated store |
| wr_addr | input | clog2(DEPTH) | Word address within the store |
| wr_data | input | 4*SLOTS | Pattern word |
| wr_inject | input | 4*SLOTS+P+1 | Codeword bit-flip mask for fault insertion |
| sw_gate | output | 1 | Switcher gate line |
| sw_clear | output | 1 | Switcher clear line |
| sw_data | output | 1 | Switcher data line |
| sw_clock | output | 1 | Switcher clock line |
| gated | output | 1 | Pins currently show gated-store slots |
| frame_start | output | 1 | First slot of row 0 on the pins |
| ecc_fix | output | 1 | Scrub rewrote a corrected word |
| ecc_dbl | output | 1 | Sticky uncorrectable-error flag |

## Verification
The bench builds the block with SLOTS=4, DEPTH=2, ROWS=8 and LEN_W=4. A row is then eight clocks long and a frame is sixty-four, so a short run covers many frame wraps and scrub passes. It also covers gated windows that open mid-frame, windows that run across the row 7 to row 0 wrap, and writes that collide with a scrub. The 16-bit word needs five check bits, so faults can be placed in data bits, in check bits and in the overall parity bit, and their effect on playback and scrub can be compared one cycle at a time.

// File: rtl/rowsw_pkg.sv
package rowsw_pkg;

  // Number of Hamming check bits for w data bits (overall parity excluded).
  function automatic int ecc_p(input int w);
    int p;
    p = 1;
    for (int k = 16; k >= 1; k--)
      if ((1 << k) >= w + k + 1) p = k;
    return p;
  endfunction

  // Syndrome value owned by data bit i: the (i+1)-th integer >= 3 that is
  // not a power of two.
  function automatic int data_code(input int i);
    int c;
    c = i + 1;
    for (int k = 0; k < 16; k++)
      if ((1 << k) <= c) c = c + 1;
    return c;
  endfunction

endpackage

// File: rtl/rowsw_ecc_enc.sv
module rowsw_ecc_enc
  import rowsw_pkg::*;
#(
  parameter int W = 16,
  parameter int P = 5,
  localparam int CW = W + P + 1
) (
  input  logic [W-1:0]  d,
  output logic [CW-1:0] cw
);
  logic [P-1:0] chk;

  always_comb begin
    chk = '0;
    for (int j = 0; j < P; j++)
      for (int i = 0; i < W; i++)
        if (((data_code(i) >> j) & 1) == 1) chk[j] = chk[j] ^ d[i];
    cw = {^{chk, d}, chk, d};
  end
endmodule

// File: rtl/rowsw_ecc_dec.sv
module rowsw_ecc_dec
  import rowsw_pkg::*;
#(
  parameter int W = 16,
  parameter int P = 5,
  localparam int CW = W + P + 1
) (
  input  logic [CW-1:0] cw,
  output logic [W-1:0]  dout,
  output logic          sgl,
  output logic          dbl
);
  logic [W-1:0] d;
  logic [P-1:0] syn;
  logic         par_bad;

  assign d = cw[W-1:0];

  always_comb begin
    syn = cw[W +: P];
    for (int j = 0; j < P; j++)
      for (int i = 0; i < W; i++)
        if (((data_code(i) >> j) & 1) == 1) syn[j] = syn[j] ^ d[i];
    par_bad = ^cw;
    sgl = par_bad;
    dbl = !par_bad && (syn != '0);
    dout = d;
    for (int i = 0; i < W; i++)
      if (par_bad && (int'(syn) == data_code(i))) dout[i] = ~d[i];
  end
endmodule

// File: rtl/rowsw_store.sv
module rowsw_store #(
  parameter int W     = 128,
  parameter int P     = 8,
  parameter int DEPTH = 4,
  localparam int CW = W + P + 1,
  localparam int AW = $clog2(DEPTH),
  localparam int NW = 2 * DEPTH,
  localparam int IW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic          wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [CW-1:0] wr_inject,
  input  logic          scrub_go,
  input  logic          rd_bank,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          ecc_fix,
  output logic          ecc_dbl
);
  logic [CW-1:0] mem [NW];
  logic          scrub_act;
  logic [IW-1:0] sc_idx;
  logic [W-1:0]  sc_data, enc_in;
  logic [CW-1:0] enc_cw;
  logic          sc_sgl, sc_dbl;
  logic [1:0]    rd_flags_unused;

  assign wr_ready = !scrub_act;
  assign enc_in   = scrub_act ? sc_data : wr_data;

  rowsw_ecc_enc #(.W(W), .P(P)) u_enc (.d(enc_in), .cw(enc_cw));

  rowsw_ecc_dec #(.W(W), .P(P)) u_dec_scrub (
    .cw(mem[sc_idx]), .dout(sc_data), .sgl(sc_sgl), .dbl(sc_dbl)
  );

  rowsw_ecc_dec #(.W(W), .P(P)) u_dec_play (
    .cw(mem[{rd_bank, rd_addr}]), .dout(rd_data),
    .sgl(rd_flags_unused[0]), .dbl(rd_flags_unused[1])
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NW; n++) mem[n] <= '0;
      scrub_act <= 1'b0;
      sc_idx    <= '0;
      ecc_fix   <= 1'b0;
      ecc_dbl   <= 1'b0;
    end else begin
      ecc_fix <= 1'b0;
      if (scrub_act) begin
        if (sc_sgl) begin
          mem[sc_idx] <= enc_cw;
          ecc_fix     <= 1'b1;
        end
        if (sc_dbl) ecc_dbl <= 1'b1;
        if (sc_idx == IW'(NW - 1)) scrub_act <= 1'b0;
        else sc_idx <= sc_idx + IW'(1);
      end else if (wr_valid) begin
        mem[{wr_bank, wr_addr}] <= enc_cw ^ wr_inject;
      end
      if (scrub_go) begin
        scrub_act <= 1'b1;
        sc_idx    <= '0;
      end
    end
  end
endmodule

// File: rtl/rowsw_timer.sv
module rowsw_timer #(
  parameter int SLOTS = 32,
  parameter int DEPTH = 4,
  parameter int ROWS  = 256,
  parameter int LEN_W = 8,
  localparam int SLW = $clog2(SLOTS),
  localparam int AW  = $clog2(DEPTH),
  localparam int RW  = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             gate_cmd,
  input  logic [RW-1:0]    gate_row,
  input  logic [LEN_W-1:0] gate_len,
  output logic [SLW-1:0]   slot,
  output logic [AW-1:0]    word,
  output logic             mode,
  output logic             at_origin
);
  logic [RW-1:0]    row, nrow, g_row;
  logic [LEN_W-1:0] grem, g_len;
  logic             pend;

  assign nrow      = (row == RW'(ROWS - 1)) ? '0 : row + RW'(1);
  assign at_origin = (slot == '0) && (word == '0) && (row == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot  <= '0;
      word  <= '0;
      row   <= '0;
      mode  <= 1'b0;
      grem  <= '0;
      pend  <= 1'b0;
      g_row <= '0;
      g_len <= '0;
    end else begin
      if (!en) begin
        slot <= '0;
        word <= '0;
        row  <= '0;
        mode <= 1'b0;
        grem <= '0;
      end else if (slot != SLW'(SLOTS - 1)) begin
        slot <= slot + SLW'(1);
      end else begin
        slot <= '0;
        if (word != AW'(DEPTH - 1)) begin
          word <= word + AW'(1);
        end else begin
          word <= '0;
          row  <= nrow;
          if (mode && (grem > LEN_W'(1))) begin
            grem <= grem - LEN_W'(1);
          end else if (pend && (nrow == g_row) && (g_len != '0)) begin
            mode <= 1'b1;
            grem <= g_len;
            pend <= 1'b0;
          end else begin
            mode <= 1'b0;
            grem <= '0;
            if (pend && (nrow == g_row)) pend <= 1'b0;
          end
        end
      end
      if (gate_cmd) begin
        pend  <= 1'b1;
        g_row <= gate_row;
        g_len <= gate_len;
      end
    end
  end
endmodule

// File: rtl/rowsw_seq.sv
module rowsw_seq
  import rowsw_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int DEPTH = 4,
  parameter int ROWS  = 256,
  parameter int LEN_W = 8,
  localparam int W   = 4 * SLOTS,
  localparam int P   = ecc_p(4 * SLOTS),
  localparam int CW  = W + P + 1,
  localparam int SLW = $clog2(SLOTS),
  localparam int AW  = $clog2(DEPTH),
  localparam int RW  = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             gate_cmd,
  input  logic [RW-1:0]    gate_row,
  input  logic [LEN_W-1:0] gate_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic             wr_bank,
  input  logic [AW-1:0]    wr_addr,
  input  logic [W-1:0]     wr_data,
  input  logic [CW-1:0]    wr_inject,
  output logic             sw_gate,
  output logic             sw_clear,
  output logic             sw_data,
  output logic             sw_clock,
  output logic             gated,
  output logic             frame_start,
  output logic             ecc_fix,
  output logic             ecc_dbl
);
  logic [SLW-1:0] slot;
  logic [AW-1:0]  word;
  logic           mode, at_origin;
  logic [W-1:0]   rd_data;
  logic [3:0]     pat, pins;

  rowsw_timer #(.SLOTS(SLOTS), .DEPTH(DEPTH), .ROWS(ROWS), .LEN_W(LEN_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .gate_cmd(gate_cmd),
    .gate_row(gate_row), .gate_len(gate_len),
    .slot(slot), .word(word), .mode(mode), .at_origin(at_origin)
  );

  rowsw_store #(.W(W), .P(P), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_bank(wr_bank),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_inject(wr_inject),
    .scrub_go(en && at_origin),
    .rd_bank(mode), .rd_addr(word), .rd_data(rd_data),
    .ecc_fix(ecc_fix), .ecc_dbl(ecc_dbl)
  );

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [SLOTS-1:0] lane;
    assign lane   = rd_data[k*SLOTS +: SLOTS];
    assign pat[k] = lane[slot];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins        <= '0;
      gated       <= 1'b0;
      frame_start <= 1'b0;
    end else if (!en) begin
      pins        <= '0;
      gated       <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      pins        <= pat;
      gated       <= mode;
      frame_start <= at_origin;
    end
  end

  assign sw_gate  = pins[0];
  assign sw_clear = pins[1];
  assign sw_data  = pins[2];
  assign sw_clock = pins[3];
endmodule

// File: rtl/rowsw_seq_chk.sv
module rowsw_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic frame_start,
  input logic wr_ready,
  input logic ecc_fix,
  input logic ecc_dbl,
  input logic sw_gate,
  input logic sw_clear,
  input logic sw_data,
  input logic sw_clock,
  input logic gated
);
  // R3: a frame start lasts one cycle
  p_fs_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R7: the scrub that a frame start launches holds the write port off
  p_fs_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !wr_ready);

  // R6: a correction report follows a cycle of scrub activity
  p_fix_in_scrub_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_fix |-> $past(!wr_ready));

  // R8: the uncorrectable flag never drops
  p_dbl_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_dbl |=> ecc_dbl);

  // R9: idle keeps every pattern pin low
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sw_gate && !sw_clear && !sw_data && !sw_clock && !gated && !frame_start));
endmodule

bind rowsw_seq rowsw_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .frame_start(frame_start),
  .wr_ready(wr_ready), .ecc_fix(ecc_fix), .ecc_dbl(ecc_dbl),
  .sw_gate(sw_gate), .sw_clear(sw_clear), .sw_data(sw_data),
  .sw_clock(sw_clock), .gated(gated)
);

// File: tb/sim_rowsw_seq.sv
`timescale 1ns/100ps
module sim_rowsw_seq;
  localparam int SLOTS = 4;
  localparam int DEPTH = 2;
  localparam int ROWS  = 8;
  localparam int LEN_W = 4;
  localparam int W  = 16;
  localparam int P  = 5;      // 2^5 >= 16 + 5 + 1
  localparam int CW = W + P + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, gate_cmd = 1'b0, wr_valid = 1'b0, wr_bank = 1'b0;
  logic [2:0] gate_row = '0;
  logic [LEN_W-1:0] gate_len = '0;
  logic [0:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [CW-1:0] wr_inject = '0;
  logic wr_ready, sw_gate, sw_clear, sw_data, sw_clock, gated, frame_start, ecc_fix, ecc_dbl;

  always #2.5 clk = ~clk;

  rowsw_seq #(.SLOTS(SLOTS), .DEPTH(DEPTH), .ROWS(ROWS), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .gate_cmd(gate_cmd), .gate_row(gate_row),
    .gate_len(gate_len), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_bank(wr_bank),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_inject(wr_inject),
    .sw_gate(sw_gate), .sw_clear(sw_clear), .sw_data(sw_data), .sw_clock(sw_clock),
    .gated(gated), .frame_start(frame_start), .ecc_fix(ecc_fix), .ecc_dbl(ecc_dbl)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [W-1:0]  m_dat [2][DEPTH];
  logic [CW-1:0] m_msk [2][DEPTH];
  int m_slot, m_word, m_row, m_grem, m_grow, m_glen, sc_k;
  bit m_act, m_pend, sc_on;
  bit e_pin [4];
  bit e_gated, e_fs, e_fix, e_dbl, e_ready;

  function automatic logic [W-1:0] shown(input int b, input int a);
    if ($countones(m_msk[b][a]) <= 1) return m_dat[b][a];
    return m_dat[b][a] ^ m_msk[b][a][W-1:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int a = 0; a < DEPTH; a++) begin
          m_dat[b][a] = '0;
          m_msk[b][a] = '0;
        end
      m_slot = 0; m_word = 0; m_row = 0; m_grem = 0; m_grow = 0; m_glen = 0;
      m_act = 0; m_pend = 0; sc_on = 0; sc_k = 0;
      for (int k = 0; k < 4; k++) e_pin[k] = 0;
      e_gated = 0; e_fs = 0; e_fix = 0; e_dbl = 0; e_ready = 1;
    end else begin
      bit origin;
      logic [W-1:0] v;
      origin = (m_row == 0) && (m_word == 0) && (m_slot == 0);
      v = shown(m_act ? 1 : 0, m_word);
      for (int k = 0; k < 4; k++) e_pin[k] = en ? v[k*SLOTS + m_slot] : 1'b0;
      e_gated = en && m_act;
      e_fs = en && origin;
      e_fix = 0;
      if (sc_on) begin
        int b, a, n;
        b = sc_k / DEPTH; a = sc_k % DEPTH;
        n = $countones(m_msk[b][a]);
        if (n == 1) begin m_msk[b][a] = '0; e_fix = 1; end
        else if (n == 2) e_dbl = 1;
        sc_k++;
        if (sc_k == 2 * DEPTH) sc_on = 0;
      end else if (wr_valid) begin
        m_dat[wr_bank][wr_addr] = wr_data;
        m_msk[wr_bank][wr_addr] = wr_inject;
      end
      if (en && origin) begin sc_on = 1; sc_k = 0; end
      if (!en) begin
        m_slot = 0; m_word = 0; m_row = 0; m_act = 0; m_grem = 0;
      end else begin
        m_slot++;
        if (m_slot == SLOTS) begin
          m_slot = 0; m_word++;
          if (m_word == DEPTH) begin
            m_word = 0;
            m_row = (m_row + 1) % ROWS;
            if (m_act && m_grem > 1) m_grem--;
            else if (m_pend && m_row == m_grow && m_glen != 0) begin
              m_act = 1; m_grem = m_glen; m_pend = 0;
            end else begin
              m_act = 0; m_grem = 0;
              if (m_pend && m_row == m_grow) m_pend = 0;
            end
          end
        end
      end
      if (gate_cmd) begin m_pend = 1; m_grow = gate_row; m_glen = gate_len; end
      e_ready = !sc_on;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !done) begin
      string t;
      t = en ? "R1/R2/R5 pins" : "R9 idle pins";
      check({t, " gate"},  sw_gate,  e_pin[0]);
      check({t, " clear"}, sw_clear, e_pin[1]);
      check({t, " data"},  sw_data,  e_pin[2]);
      check({t, " clock"}, sw_clock, e_pin[3]);
      check("R4 gated", gated, e_gated);
      check("R3 frame_start", frame_start, e_fs);
      check("R7 wr_ready", wr_ready, e_ready);
      check("R6 ecc_fix", ecc_fix, e_fix);
      check("R8 ecc_dbl", ecc_dbl, e_dbl);
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit b, input bit a, input logic [W-1:0] d, input logic [CW-1:0] inj);
    @(negedge clk);
    wr_valid = 1; wr_bank = b; wr_addr = a; wr_data = d; wr_inject = inj;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 0; wr_inject = '0;
  endtask

  task automatic gate(input int row, input int len);
    @(negedge clk);
    gate_cmd = 1; gate_row = 3'(row); gate_len = LEN_W'(len);
    @(negedge clk);
    gate_cmd = 0;
  endtask

  initial begin
    cyc(4);
    rst_n = 1;
    @(negedge clk);
    // R9: reset state
    check("R9 reset pins", {sw_clock, sw_data, sw_clear, sw_gate}, 0);
    check("R9 reset ready", wr_ready, 1);
    check("R9 reset flags", {ecc_fix, ecc_dbl, gated, frame_start}, 0);

    // R7: load both stores while idle
    wr(0, 0, 16'hA5C3, '0);
    wr(0, 1, 16'h3C96, '0);
    wr(1, 0, 16'hF00F, '0);
    wr(1, 1, 16'h1248, '0);

    // R1/R3: plain running across frame wraps
    en = 1;
    cyc(150);
    // R4: gated window mid-frame, then one across the frame wrap
    gate(3, 2);
    cyc(140);
    gate(7, 3);
    cyc(140);
    // R4: zero length is dropped; a newer command replaces a pending one
    gate(2, 0);
    cyc(70);
    gate(5, 1);
    gate(6, 2);
    cyc(140);
    // R5/R6: single faults in data, check and overall bits
    wr(0, 1, 16'h3C96, CW'(1) << 5);
    cyc(100);
    wr(1, 0, 16'hF00F, CW'(1) << (W + 1));
    wr(1, 1, 16'h1248, CW'(1) << (W + P));
    gate(1, 4);
    cyc(140);
    // R8: double fault stays, flag sticks
    wr(1, 1, 16'h1248, (CW'(1) << 2) | (CW'(1) << 9));
    gate(4, 2);
    cyc(140);
    // R7: back-to-back writes, some against a scrub
    for (int i = 0; i < 12; i++) wr(0, 1'(i), 16'(16'h0F1E + i * 16'h1111), '0);
    cyc(70);
    // R9: idle in the middle of a frame drops a running window
    gate(2, 5);
    cyc(40);
    en = 0;
    cyc(20);
    en = 1;
    cyc(100);
    // R8: clean rewrite leaves the flag set
    wr(1, 1, 16'h1248, '0);
    cyc(80);
    check("R8 sticky after rewrite", ecc_dbl, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule